// File: doc/BRIEF.md
# Four-State Adjacency-Coded Sequence Controller

This block is a synchronous four-state Mealy machine with a fixed transition table. It has one steering input, `x_in`. It produces one flag, `z_out`, and it drives its two state bits out so that neighbouring logic and checkers can observe them. The four states are called A, B, C and D.

The state codes are chosen so that states with a common successor, or states reached from a common predecessor, differ in one bit. Under this coding each next-state bit reduces to a two-input selection on `x_in`, and the flag reduces to an AND of the two state bits.

A synchronous, active-high clear returns the machine to A. The state register changes only on the rising edge of `clk`. The flag is combinational from the present state.

Top module: `adj_mealy4`

## Requirements
- R1: When `clr` is 1 at a rising edge, the state after that edge is A. This holds regardless of `x_in` and of the present state, and clear takes precedence over every transition.
- R2: The state codes on `state_q` are A=2'b00, B=2'b01, C=2'b10 and D=2'b11. Bit 1 is the first state variable and bit 0 is the second.
- R3: From A with `clr`=0, an edge with `x_in`=0 moves to C and an edge with `x_in`=1 moves to D.
- R4: From B with `clr`=0, an edge with `x_in`=0 moves to C and an edge with `x_in`=1 moves to A.
- R5: From C with `clr`=0, an edge with `x_in`=0 moves to B and an edge with `x_in`=1 moves to D.
- R6: From D with `clr`=0, an edge with `x_in`=0 moves to A and an edge with `x_in`=1 moves to B.
- R7: `z_out` is 1 exactly when the present state is D. The value of `x_in` has no effect on it, and it is valid in the same cycle as the state, without a register.
- R8: While `clr` is 1, `z_out` still reflects the present state. Clear affects only the state after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear to state A |
| x_in | input | 1 | Steering input that selects the transition |
| z_out | output | 1 | Mealy flag, 1 in state D |
| state_q | output | 2 | Present state code (bit 1, bit 0) |

## Verification
Clear and an ordinary transition can fall on the same edge. So can clear and an asserted flag. The bench walks the machine into D and then raises `clr` with `x_in` at both values. In that cycle it checks two things. `z_out` must still read 1, because the machine is still in D. After the edge the state must be A, not the table's successor B. A second collision raises clear in C with `x_in`=1, where the table would lead to D, and checks that the state returns to A instead.

// File: rtl/adj_mealy4_pkg.sv
package adj_mealy4_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_A = 2'b00,
    ST_B = 2'b01,
    ST_C = 2'b10,
    ST_D = 2'b11
  } adj_state_e;
endpackage

// File: rtl/adj_next_logic.sv
module adj_next_logic
  import adj_mealy4_pkg::*;
(
  input  logic [STATE_W-1:0] cur_st,
  input  logic               steer,
  output logic [STATE_W-1:0] nxt_st
);
  logic hi_b;
  logic lo_b;

  assign hi_b = cur_st[1];
  assign lo_b = cur_st[0];

  // Adjacent coding: each next bit is a mux on steer of simple terms.
  always_comb begin
    if (steer) begin
      nxt_st[1] = ~lo_b;
      nxt_st[0] = hi_b | ~lo_b;
    end else begin
      nxt_st[1] = ~hi_b;
      nxt_st[0] = hi_b & ~lo_b;
    end
  end
endmodule

// File: rtl/adj_out_logic.sv
module adj_out_logic
  import adj_mealy4_pkg::*;
(
  input  logic [STATE_W-1:0] cur_st,
  input  logic               steer,
  output logic               flag
);
  logic unused_steer;

  // The flag does not depend on steer, which is kept here only as the Mealy input.
  assign unused_steer = steer;
  assign flag = cur_st[1] & cur_st[0];
endmodule

// File: rtl/adj_state_reg.sv
module adj_state_reg
  import adj_mealy4_pkg::*;
#(
  parameter logic [STATE_W-1:0] CLR_CODE = ST_A
) (
  input  logic               clk,
  input  logic               clr,
  input  logic [STATE_W-1:0] d_st,
  output logic [STATE_W-1:0] q_st
);
  always_ff @(posedge clk) begin
    if (clr) q_st <= CLR_CODE;
    else     q_st <= d_st;
  end

  // R1
  clear_to_home_chk: assert property (@(posedge clk) clr |=> (q_st == CLR_CODE));

  // R1
  load_next_chk: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (q_st == $past(d_st)));
endmodule

// File: rtl/adj_mealy4.sv
module adj_mealy4
  import adj_mealy4_pkg::*;
(
  input  logic               clk,
  input  logic               clr,
  input  logic               x_in,
  output logic               z_out,
  output logic [STATE_W-1:0] state_q
);
  logic [STATE_W-1:0] nxt_w;

  adj_next_logic u_next (
    .cur_st (state_q),
    .steer  (x_in),
    .nxt_st (nxt_w)
  );

  adj_out_logic u_out (
    .cur_st (state_q),
    .steer  (x_in),
    .flag   (z_out)
  );

  adj_state_reg #(.CLR_CODE(ST_A)) u_reg (
    .clk  (clk),
    .clr  (clr),
    .d_st (nxt_w),
    .q_st (state_q)
  );

  // R3
  from_a_chk: assert property (@(posedge clk) disable iff (clr)
    (state_q == ST_A) |=> (state_q == ($past(x_in) ? ST_D : ST_C)));

  // R4
  from_b_chk: assert property (@(posedge clk) disable iff (clr)
    (state_q == ST_B) |=> (state_q == ($past(x_in) ? ST_A : ST_C)));

  // R5
  from_c_chk: assert property (@(posedge clk) disable iff (clr)
    (state_q == ST_C) |=> (state_q == ($past(x_in) ? ST_D : ST_B)));

  // R6
  from_d_chk: assert property (@(posedge clk) disable iff (clr)
    (state_q == ST_D) |=> (state_q == ($past(x_in) ? ST_B : ST_A)));

  // R7
  flag_leaves_d_chk: assert property (@(posedge clk) disable iff (clr)
    z_out |=> (state_q[1] == 1'b0));

  // R8
  flag_under_clear_chk: assert property (@(posedge clk)
    (clr && (state_q == ST_D)) |-> z_out);
endmodule

// File: tb/adj_mealy4_tb_top.sv
module adj_mealy4_tb_top;
  localparam logic [1:0] A = 2'b00, B = 2'b01, C = 2'b10, D = 2'b11;

  logic       clk = 1'b0;
  logic       clr;
  logic       x_in;
  logic       z_out;
  logic [1:0] state_q;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] model_st;

  always #2.5 clk = ~clk;

  adj_mealy4 dut_i (
    .clk     (clk),
    .clr     (clr),
    .x_in    (x_in),
    .z_out   (z_out),
    .state_q (state_q)
  );

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic x);
    case (s)
      A: ref_next = x ? D : C;
      B: ref_next = x ? A : C;
      C: ref_next = x ? D : B;
      default: ref_next = x ? B : A;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      A: tag_of = "R3";
      B: tag_of = "R4";
      C: tag_of = "R5";
      default: tag_of = "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check flag mid-cycle, check state after the edge.
  task automatic step(input logic x, input logic c, input string req_flag);
    logic [1:0] exp_nxt;
    @(negedge clk);
    x_in = x;
    clr  = c;
    #1;
    check(req_flag, {1'b0, z_out}, {1'b0, model_st == D});
    exp_nxt = c ? A : ref_next(model_st, x);
    @(posedge clk);
    #1;
    check(c ? "R1" : tag_of(model_st), state_q, exp_nxt);
    model_st = exp_nxt;
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, "R7");
    check("R2", state_q, 2'b00);
    check("R7", {1'b0, z_out}, 2'b00);
  endtask

  // Visits every state/input pair: A0 C0 B0 C1 D0 A1 D1 B1
  task automatic t_walk;
    logic xs [8] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    for (int i = 0; i < 8; i++) step(xs[i], 1'b0, "R7");
    check("R2", state_q, A);
  endtask

  // Flag is independent of x: sit in D, flip x before the edge.
  task automatic t_flag_x_free;
    step(1'b1, 1'b0, "R7");
    @(negedge clk);
    x_in = 1'b0; #1;
    check("R7", {1'b0, z_out}, 2'b01);
    x_in = 1'b1; #1;
    check("R7", {1'b0, z_out}, 2'b01);
    check("R2", state_q, 2'b11);
    clr = 1'b0;
    @(posedge clk); #1;
    check("R6", state_q, B);
    model_st = B;
  endtask

  // Clear colliding with a flag and with transitions.
  task automatic t_clear_collide;
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, "R8");
  endtask

  initial begin
    clr = 1'b1;
    x_in = 1'b0;
    model_st = A;
    t_reset();
    t_walk();
    t_flag_x_free();
    t_clear_collide();
    t_walk();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #20000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule